// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Arbiter

This block decides, separately for every processor, which interrupt that processor should take next. It keeps the pending state of every interrupt for every processor. A scan engine visits one interrupt per clock and looks for the enabled, pending interrupt with the best priority. When a scan finishes, the engine compares that priority with the processor's priority mask and with its running priority. The result drives the processor's request line and a reported highest-pending ID.

Every processor reaches the block through one shared command port. It offers three operations: acknowledge, end-of-interrupt and priority-mask write. An acknowledge that succeeds makes the winning interrupt the running one and stores the previous running ID as its predecessor in a per-processor link memory. Preemption can therefore nest. An end-of-interrupt may name any interrupt on that chain, and the block unlinks it with a walk of one link per clock. Decoding of the distributor registers happens outside this block, and so does sampling of the interrupt inputs.

Top module: `prio_irq_arbiter`

## Requirements
- R1: Among interrupts that are enabled and pending for a processor, the numerically lowest 8-bit priority wins, and the lowest ID breaks ties. `hp_id` shows the winner when its priority is at or below that processor's mask, and 1023 otherwise.
- R2: `irq_req[c]` is high only when the winning priority is at or below the mask and strictly below the running priority. The running priority is 0x100 while nothing is running.
- R3: While `dist_en` is low, or `cpu_en[c]` is low, `irq_req[c]` is low and `hp_id` slot c reads 1023.
- R4: An acknowledge (`cmd_op`=0) returns 1023 on `rsp_id` one cycle later in two cases: no interrupt is reported pending, or the pending priority is not strictly better than the running priority. Running state and pending state do not change.
- R5: A successful acknowledge returns the winning ID, which becomes the running interrupt, and records the former running ID as its predecessor. It clears the pending bit of the winning ID on every processor when `irq_one_of_n` is 1, and only on the acknowledging processor when it is 0.
- R6: An end-of-interrupt (`cmd_op`=1, ID in `cmd_data`) that names the running ID makes that ID's predecessor the running interrupt again. The predecessor may be 1023.
- R7: An end-of-interrupt that names a non-running ID removes that ID from the processor's predecessor chain without changing the running interrupt. `cmd_ready` stays low until the walk has finished.
- R8: An end-of-interrupt sets the named ID pending again for that processor when the ID is level-triggered (`irq_edge`=0), enabled, has its level high and targets that processor.
- R9: An end-of-interrupt has no effect while the processor has nothing running.
- R10: The priority mask of every processor is 0xF0 after reset. A mask write (`cmd_op`=2) keeps only `cmd_data[7:0]`.
- R11: Every accepted command restarts the scan. `cmd_ready` is low for exactly NUM_IRQ cycles after acceptance, unless a walk takes longer. Request and highest-pending outputs change only when a scan completes.
- R12: A `pend_set` pulse for an interrupt in the same cycle as the acknowledge that clears that interrupt leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global distribution enable |
| cpu_en | input | NUM_CPU | Per-processor interface enable |
| irq_en | input | NUM_IRQ | Per-interrupt enable |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| irq_level | input | NUM_IRQ | Current asserted level of each interrupt |
| irq_one_of_n | input | NUM_IRQ | 1 = acknowledge clears pending on all processors |
| irq_target | input | NUM_IRQ*NUM_CPU | Bit i*NUM_CPU+c: interrupt i targets processor c |
| irq_prio | input | NUM_IRQ*8 | Bits [8i+7:8i]: priority of interrupt i |
| pend_set | input | NUM_IRQ*NUM_CPU | Bit i*NUM_CPU+c: set interrupt i pending for processor c |
| cmd_valid | input | 1 | Command request |
| cmd_cpu | input | CPU_W | Processor issuing the command |
| cmd_op | input | 2 | 0 acknowledge, 1 end-of-interrupt, 2 mask write, 3 no-op |
| cmd_data | input | 10 | Interrupt ID or mask value |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| rsp_valid | output | 1 | Acknowledge result valid |
| rsp_id | output | 10 | Acknowledged ID, or 1023 |
| irq_req | output | NUM_CPU | Request line per processor |
| hp_id | output | NUM_CPU*10 | Highest-pending ID per processor, slot c at [10c+9:10c] |

## Verification
Two functions can fall in the same clock edge. One is an external set-pending pulse for an interrupt. The other is the acknowledge that clears that same interrupt. The bench drives `pend_set` for the winning ID in the same cycle in which it presents the acknowledge. It then expects the acknowledge to return that ID, and expects the ID to be reported pending again once the following scan completes. Random traffic mixes the same collisions with nested acknowledges and out-of-order completions, and a reference model of pending bits, running IDs and predecessor chains judges each result.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int ID_W   = 10;
   localparam int PRIO_W = 8;
   typedef logic [ID_W-1:0]   irq_id_t;
   typedef logic [PRIO_W:0]   rprio_t;
   localparam irq_id_t NONE_ID   = irq_id_t'(1023);
   localparam rprio_t  IDLE_PRIO = rprio_t'(9'h100);
   localparam logic [PRIO_W-1:0] MASK_RST = 8'hF0;
   typedef enum logic [1:0] {
      OP_ACK  = 2'd0,
      OP_EOI  = 2'd1,
      OP_MASK = 2'd2,
      OP_NOP  = 2'd3
   } op_e;
endpackage

// File: rtl/arb_scan_unit.sv
module arb_scan_unit
   import arb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              last,
   input  irq_id_t           cand_id,
   input  logic              cand_valid,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic              gate_en,
   input  logic [PRIO_W-1:0] mask,
   input  rprio_t            run_prio,
   output irq_id_t           hp_id,
   output rprio_t            hp_prio,
   output logic              req
);
   rprio_t  best_prio, fin_prio;
   irq_id_t best_id, fin_id;
   logic    take;

   always_comb begin
      take     = cand_valid && ({1'b0, cand_prio} < best_prio);
      fin_prio = take ? {1'b0, cand_prio} : best_prio;
      fin_id   = take ? cand_id : best_id;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         best_prio <= IDLE_PRIO;
         best_id   <= NONE_ID;
         hp_id     <= NONE_ID;
         hp_prio   <= IDLE_PRIO;
         req       <= 1'b0;
      end else if (restart) begin
         best_prio <= IDLE_PRIO;
         best_id   <= NONE_ID;
      end else if (last) begin
         best_prio <= IDLE_PRIO;
         best_id   <= NONE_ID;
         if (gate_en && fin_prio <= {1'b0, mask}) begin
            hp_id   <= fin_id;
            hp_prio <= fin_prio;
            req     <= fin_prio < run_prio;
         end else begin
            hp_id   <= NONE_ID;
            hp_prio <= IDLE_PRIO;
            req     <= 1'b0;
         end
      end else if (take) begin
         best_prio <= fin_prio;
         best_id   <= fin_id;
      end
   end

   // R2: a raised request always has a reported winner
   a_r2_req_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (hp_id != NONE_ID));
   // R11: reported winner moves only at the end of a scan
   a_r11_latch_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hp_id) |-> $past(last));
   // R1: a reported winner carries a real 8-bit priority
   a_r1_winner_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_id != NONE_ID) |-> (hp_prio[PRIO_W] == 1'b0));
endmodule

// File: rtl/arb_link_walker.sv
module arb_link_walker
   import arb_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_IRQ = 32,
   localparam int IDX_W = $clog2(NUM_IRQ),
   localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CPU_W-1:0] rd_cpu,
   input  logic [IDX_W-1:0] rd_idx,
   output irq_id_t          rd_data,
   input  logic             lk_we,
   input  logic [CPU_W-1:0] lk_cpu,
   input  logic [IDX_W-1:0] lk_idx,
   input  irq_id_t          lk_pred,
   input  logic             st_go,
   input  logic [CPU_W-1:0] st_cpu,
   input  irq_id_t          st_head,
   input  logic [IDX_W-1:0] st_target,
   output logic             busy
);
   localparam irq_id_t LAST_ID = irq_id_t'(NUM_IRQ - 1);

   irq_id_t          link_q [NUM_CPU][NUM_IRQ];
   logic [CPU_W-1:0] w_cpu;
   irq_id_t          w_cur;
   logic [IDX_W-1:0] w_tgt;
   logic [IDX_W:0]   w_steps;
   irq_id_t          nxt;
   logic             hit, stop;

   assign rd_data = link_q[rd_cpu][rd_idx];

   always_comb begin
      nxt  = link_q[w_cpu][w_cur[IDX_W-1:0]];
      hit  = (nxt == irq_id_t'(w_tgt));
      stop = (nxt == NONE_ID) || (nxt > LAST_ID) ||
             (w_steps == (IDX_W+1)'(NUM_IRQ));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NUM_CPU; c++)
            for (int i = 0; i < NUM_IRQ; i++)
               link_q[c][i] <= NONE_ID;
         busy    <= 1'b0;
         w_cpu   <= '0;
         w_cur   <= NONE_ID;
         w_tgt   <= '0;
         w_steps <= '0;
      end else begin
         if (lk_we)
            link_q[lk_cpu][lk_idx] <= lk_pred;
         if (st_go) begin
            busy    <= 1'b1;
            w_cpu   <= st_cpu;
            w_cur   <= st_head;
            w_tgt   <= st_target;
            w_steps <= '0;
         end else if (busy) begin
            if (hit) begin
               link_q[w_cpu][w_cur[IDX_W-1:0]] <= link_q[w_cpu][w_tgt];
               busy <= 1'b0;
            end else if (stop) begin
               busy <= 1'b0;
            end else begin
               w_cur   <= nxt;
               w_steps <= w_steps + 1'b1;
            end
         end
      end
   end

   // R7: the command port is stalled for the whole walk
   a_r7_no_link_write_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !lk_we);
   a_r7_no_restart_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !st_go);
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
   import arb_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_IRQ = 32,
   localparam int IDX_W = $clog2(NUM_IRQ),
   localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        dist_en,
   input  logic [NUM_CPU-1:0]          cpu_en,
   input  logic [NUM_IRQ-1:0]          irq_en,
   input  logic [NUM_IRQ-1:0]          irq_edge,
   input  logic [NUM_IRQ-1:0]          irq_level,
   input  logic [NUM_IRQ-1:0]          irq_one_of_n,
   input  logic [NUM_IRQ*NUM_CPU-1:0]  irq_target,
   input  logic [NUM_IRQ*PRIO_W-1:0]   irq_prio,
   input  logic [NUM_IRQ*NUM_CPU-1:0]  pend_set,
   input  logic                        cmd_valid,
   input  logic [CPU_W-1:0]            cmd_cpu,
   input  logic [1:0]                  cmd_op,
   input  logic [ID_W-1:0]             cmd_data,
   output logic                        cmd_ready,
   output logic                        rsp_valid,
   output logic [ID_W-1:0]             rsp_id,
   output logic [NUM_CPU-1:0]          irq_req,
   output logic [NUM_CPU*ID_W-1:0]     hp_id
);
   localparam irq_id_t LAST_ID = irq_id_t'(NUM_IRQ - 1);

   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 1..8");
   end
   if (NUM_IRQ < 2 || NUM_IRQ > 1020) begin : g_bad_irq
      $error("NUM_IRQ must be 2..1020");
   end

   logic [NUM_CPU-1:0][NUM_IRQ-1:0] pend_q, pend_d;
   logic [PRIO_W-1:0] prio_arr [NUM_IRQ];
   irq_id_t           hp_w   [NUM_CPU];
   rprio_t            hpp_w  [NUM_CPU];
   irq_id_t           run_id [NUM_CPU];
   rprio_t            run_pr [NUM_CPU];
   logic [PRIO_W-1:0] mask_q [NUM_CPU];
   logic [IDX_W-1:0]  scan_idx;
   logic              last, stale, walk_busy, fire;
   op_e               op;
   irq_id_t           sel_hp, sel_run, link_rd;
   logic              ack_fire, ack_ok, eoi_fire, eoi_in, eoi_run, repend;
   logic [IDX_W-1:0]  hp_idx, eidx;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
      assign prio_arr[i] = irq_prio[i*PRIO_W +: PRIO_W];
   end

   assign last      = (scan_idx == IDX_W'(NUM_IRQ - 1));
   assign cmd_ready = !stale && !walk_busy;
   assign fire      = cmd_valid && cmd_ready;
   assign op        = op_e'(cmd_op);
   assign sel_hp    = hp_w[cmd_cpu];
   assign sel_run   = run_id[cmd_cpu];
   assign hp_idx    = sel_hp[IDX_W-1:0];
   assign eidx      = cmd_data[IDX_W-1:0];
   assign ack_fire  = fire && (op == OP_ACK);
   assign ack_ok    = ack_fire && (sel_hp != NONE_ID) && (hpp_w[cmd_cpu] < run_pr[cmd_cpu]);
   assign eoi_fire  = fire && (op == OP_EOI) && (sel_run != NONE_ID);
   assign eoi_in    = (cmd_data <= LAST_ID);
   assign eoi_run   = eoi_fire && (cmd_data == sel_run);
   assign repend    = eoi_fire && eoi_in && !irq_edge[eidx] && irq_en[eidx] &&
                      irq_level[eidx] && irq_target[eidx*NUM_CPU + int'(cmd_cpu)];

   always_comb begin
      pend_d = pend_q;
      for (int c = 0; c < NUM_CPU; c++) begin
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (ack_ok && i == int'(hp_idx) && (irq_one_of_n[i] || c == int'(cmd_cpu)))
               pend_d[c][i] = 1'b0;
            if (repend && i == int'(eidx) && c == int'(cmd_cpu))
               pend_d[c][i] = 1'b1;
            if (pend_set[i*NUM_CPU + c])
               pend_d[c][i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= '0;
         scan_idx  <= '0;
         stale     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_id    <= NONE_ID;
         for (int c = 0; c < NUM_CPU; c++) begin
            run_id[c] <= NONE_ID;
            run_pr[c] <= IDLE_PRIO;
            mask_q[c] <= MASK_RST;
         end
      end else begin
         pend_q    <= pend_d;
         rsp_valid <= ack_fire;
         rsp_id    <= ack_ok ? sel_hp : NONE_ID;
         if (fire) begin
            scan_idx <= '0;
            stale    <= 1'b1;
         end else if (last) begin
            scan_idx <= '0;
            stale    <= 1'b0;
         end else begin
            scan_idx <= scan_idx + 1'b1;
         end
         if (ack_ok) begin
            run_id[cmd_cpu] <= sel_hp;
            run_pr[cmd_cpu] <= {1'b0, prio_arr[hp_idx]};
         end
         if (eoi_run) begin
            run_id[cmd_cpu] <= link_rd;
            run_pr[cmd_cpu] <= (link_rd == NONE_ID) ? IDLE_PRIO
                                                    : {1'b0, prio_arr[link_rd[IDX_W-1:0]]};
         end
         if (fire && op == OP_MASK)
            mask_q[cmd_cpu] <= cmd_data[PRIO_W-1:0];
      end
   end

   arb_link_walker #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_cpu    (cmd_cpu),
      .rd_idx    (eidx),
      .rd_data   (link_rd),
      .lk_we     (ack_ok),
      .lk_cpu    (cmd_cpu),
      .lk_idx    (hp_idx),
      .lk_pred   (sel_run),
      .st_go     (eoi_fire && !eoi_run && eoi_in),
      .st_cpu    (cmd_cpu),
      .st_head   (sel_run),
      .st_target (eidx),
      .busy      (walk_busy)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      arb_scan_unit u_scan (
         .clk        (clk),
         .rst_n      (rst_n),
         .restart    (fire),
         .last       (last),
         .cand_id    (irq_id_t'(scan_idx)),
         .cand_valid (irq_en[scan_idx] && pend_q[c][scan_idx]),
         .cand_prio  (prio_arr[scan_idx]),
         .gate_en    (dist_en && cpu_en[c]),
         .mask       (mask_q[c]),
         .run_prio   (run_pr[c]),
         .hp_id      (hp_w[c]),
         .hp_prio    (hpp_w[c]),
         .req        (irq_req[c])
      );
      assign hp_id[c*ID_W +: ID_W] = hp_w[c];

      // R9: end-of-interrupt with nothing running leaves it idle
      a_r9_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (fire && op == OP_EOI && cmd_cpu == CPU_W'(c) && run_id[c] == NONE_ID)
            |=> (run_id[c] == NONE_ID));
      // R5: a granted ID becomes the running one
      a_r5_grant_runs: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && rsp_id != NONE_ID && $past(cmd_cpu) == CPU_W'(c))
            |-> (run_id[c] == rsp_id));
   end

   // R4: acknowledge with nothing reported returns the none ID
   a_r4_nack_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && sel_hp == NONE_ID) |=> (rsp_valid && rsp_id == NONE_ID));
   // R11: an accepted command starts a fresh scan and stalls the port
   a_r11_stall_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !cmd_ready);
endmodule

// File: tb/sim_prio_irq_arbiter.sv
`timescale 1ns/1ps
module sim_prio_irq_arbiter;
   localparam int NC = 2;
   localparam int NI = 32;
   localparam int NONE = 1023;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dist_en;
   logic [NC-1:0] cpu_en;
   logic [NI-1:0] irq_en, irq_edge, irq_level, irq_oon;
   logic [NI*NC-1:0] irq_target, pend_set;
   logic [NI*8-1:0] irq_prio;
   logic cmd_valid;
   logic [0:0] cmd_cpu;
   logic [1:0] cmd_op;
   logic [9:0] cmd_data;
   logic cmd_ready, rsp_valid;
   logic [9:0] rsp_id;
   logic [NC-1:0] irq_req;
   logic [NC*10-1:0] hp_id;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   bit m_pend [NC][NI];
   int m_run [NC];
   int m_rprio [NC];
   int m_mask [NC];
   int m_chain [NC][NI];

   always #2.5 clk = ~clk;

   prio_irq_arbiter #(.NUM_CPU(NC), .NUM_IRQ(NI)) u0 (
      .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
      .irq_en(irq_en), .irq_edge(irq_edge), .irq_level(irq_level),
      .irq_one_of_n(irq_oon), .irq_target(irq_target), .irq_prio(irq_prio),
      .pend_set(pend_set), .cmd_valid(cmd_valid), .cmd_cpu(cmd_cpu),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .irq_req(irq_req), .hp_id(hp_id)
   );

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int prio(int i);
      return int'(irq_prio[i*8 +: 8]);
   endfunction

   function automatic int exp_hp(int c);
      int best = 256;
      int bid = NONE;
      if (!(dist_en && cpu_en[c])) return NONE;
      for (int i = 0; i < NI; i++)
         if (irq_en[i] && m_pend[c][i] && prio(i) < best) begin
            best = prio(i);
            bid = i;
         end
      return (best <= m_mask[c]) ? bid : NONE;
   endfunction

   function automatic int exp_req(int c);
      int h = exp_hp(c);
      return (h != NONE && prio(h) < m_rprio[c]) ? 1 : 0;
   endfunction

   function automatic int model_ack(int c);
      int h = exp_hp(c);
      if (h == NONE || prio(h) >= m_rprio[c]) return NONE;
      m_chain[c][h] = m_run[c];
      for (int k = 0; k < NC; k++)
         if (irq_oon[h] || k == c) m_pend[k][h] = 0;
      m_run[c] = h;
      m_rprio[c] = prio(h);
      return h;
   endfunction

   function automatic void model_eoi(int c, int e);
      int t;
      if (m_run[c] == NONE) return;
      if (e < NI && !irq_edge[e] && irq_en[e] && irq_level[e] && irq_target[e*NC+c])
         m_pend[c][e] = 1;
      if (e == m_run[c]) begin
         m_run[c] = m_chain[c][e];
         m_rprio[c] = (m_run[c] == NONE) ? 256 : prio(m_run[c]);
      end else if (e < NI) begin
         t = m_run[c];
         while (m_chain[c][t] != NONE) begin
            if (m_chain[c][t] == e) begin
               m_chain[c][t] = m_chain[c][e];
               break;
            end
            t = m_chain[c][t];
         end
      end
   endfunction

   task automatic issue(int c, int op, int data, output int rid, output int lowcnt);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_cpu = c[0:0];
      cmd_op = op[1:0];
      cmd_data = data[9:0];
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      rid = rsp_valid ? int'(rsp_id) : -1;
      lowcnt = 0;
      while (!cmd_ready) begin
         lowcnt++;
         @(negedge clk);
      end
   endtask

   task automatic settle_check(string tag);
      repeat (2*NI + 2) @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         chk({tag, " hp"}, int'(hp_id[c*10 +: 10]), exp_hp(c));
         chk({tag, " req"}, int'(irq_req[c]), exp_req(c));
      end
   endtask

   task automatic pulse(int c, int i);
      pend_set[i*NC + c] = 1'b1;
      m_pend[c][i] = 1;
      @(negedge clk);
      pend_set = '0;
   endtask

   task automatic do_ack(int c, string tag, output int got);
      int e, lc;
      e = model_ack(c);
      issue(c, 0, 0, got, lc);
      chk({tag, " ack id"}, got, e);
   endtask

   task automatic do_eoi(int c, int e);
      int r, lc;
      model_eoi(c, e);
      issue(c, 1, e, r, lc);
   endtask

   task automatic do_mask(int c, int v, output int lc);
      int r;
      m_mask[c] = v & 255;
      issue(c, 2, v, r, lc);
   endtask

   function automatic int hp(int c);
      return int'(hp_id[c*10 +: 10]);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      int got, lc, c, i, r, e;
      void'($urandom(32'd20240611));
      dist_en = 0; cpu_en = '0;
      irq_en = '1; irq_edge = '1; irq_level = '0; irq_oon = '0;
      irq_target = '1; pend_set = '0;
      for (int k = 0; k < NI; k++) irq_prio[k*8 +: 8] = 8'h80;
      cmd_valid = 0; cmd_cpu = '0; cmd_op = '0; cmd_data = '0;
      for (int k = 0; k < NC; k++) begin
         m_run[k] = NONE; m_rprio[k] = 256; m_mask[k] = 240;
         for (int j = 0; j < NI; j++) begin m_pend[k][j] = 0; m_chain[k][j] = NONE; end
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset R3 hp0", hp(0), NONE);
      chk("reset R3 req", int'(irq_req), 0);
      // R3: pending but distribution off
      pulse(0, 4);
      settle_check("R3 gated");
      chk("R3 gated hp0", hp(0), NONE);
      dist_en = 1; cpu_en = 2'b11;
      settle_check("R1 single");
      chk("R1 single hp0", hp(0), 4);
      do_ack(0, "R5 first", got);
      do_eoi(0, 4);
      // R10: reset mask 0xF0 and 8-bit writes
      irq_prio[5*8 +: 8] = 8'hF0;
      irq_prio[6*8 +: 8] = 8'hF1;
      pulse(0, 6);
      settle_check("R10 above mask");
      chk("R10 F1 hidden", hp(0), NONE);
      pulse(0, 5);
      settle_check("R10 at mask");
      chk("R10 F0 visible", hp(0), 5);
      do_ack(0, "R10", got);
      do_eoi(0, 5);
      do_mask(0, 10'h1F0, lc);
      chk("R11 ready low cycles", lc, NI);
      settle_check("R10 truncate");
      chk("R10 truncated mask", hp(0), NONE);
      do_mask(0, 10'h0F1, lc);
      settle_check("R10 mask F1");
      chk("R10 mask F1", hp(0), 6);
      // R1: tie on priority, lowest ID wins
      irq_prio[9*8 +: 8] = 8'h40;
      irq_prio[3*8 +: 8] = 8'h40;
      pulse(0, 9);
      pulse(0, 3);
      settle_check("R1 tie");
      chk("R1 tie hp0", hp(0), 3);
      do_ack(0, "R1 tie", got);
      do_eoi(0, 3);
      do_ack(0, "R1 next", got);
      chk("R1 next id", got, 9);
      do_eoi(0, 9);
      // R5/R6/R7: nesting and out-of-order completion
      irq_prio[10*8 +: 8] = 8'h80;
      irq_prio[11*8 +: 8] = 8'h40;
      irq_prio[12*8 +: 8] = 8'h20;
      pulse(0, 10);
      settle_check("R5 nest a");
      do_ack(0, "R5 nest a", got);
      chk("R5 nest a id", got, 10);
      settle_check("R2 lower hidden");
      chk("R2 no req F1 vs 80", int'(irq_req[0]), 0);
      pulse(0, 11);
      settle_check("R2 preempt");
      chk("R2 preempt req", int'(irq_req[0]), 1);
      do_ack(0, "R5 nest b", got);
      pulse(0, 12);
      settle_check("R5 nest c");
      do_ack(0, "R5 nest c", got);
      chk("R5 nest c id", got, 12);
      do_eoi(0, 11);
      settle_check("R7 unlink");
      do_eoi(0, 12);
      pulse(0, 11);
      settle_check("R7 chain fixed");
      chk("R7 restored to 10", int'(irq_req[0]), 1);
      do_ack(0, "R6 reack", got);
      do_eoi(0, 11);
      do_eoi(0, 10);
      settle_check("R6 idle");
      chk("R6 back to idle", int'(irq_req[0]), 1);
      // R9 and R8 on processor 1
      irq_edge[20] = 0; irq_level[20] = 1; irq_prio[20*8 +: 8] = 8'h30;
      do_eoi(1, 20);
      settle_check("R9 idle eoi");
      chk("R9 no repend", hp(1), NONE);
      pulse(1, 20);
      settle_check("R8 setup");
      do_ack(1, "R8", got);
      do_eoi(1, 20);
      settle_check("R8 repend");
      chk("R8 repend hp1", hp(1), 20);
      do_ack(1, "R8 b", got);
      irq_level[20] = 0;
      do_eoi(1, 20);
      settle_check("R8 low level");
      chk("R8 no repend low", hp(1), NONE);
      // R5: one-of-N versus N-of-N clearing
      irq_oon[25] = 1; irq_prio[25*8 +: 8] = 8'h50;
      pulse(0, 25); pulse(1, 25);
      settle_check("R5 oon");
      do_ack(0, "R5 oon", got);
      settle_check("R5 oon cleared");
      chk("R5 oon other cpu", hp(1), NONE);
      do_eoi(0, 25);
      irq_prio[26*8 +: 8] = 8'h50;
      pulse(0, 26); pulse(1, 26);
      settle_check("R5 non");
      do_ack(0, "R5 non", got);
      settle_check("R5 non kept");
      chk("R5 non other cpu", hp(1), 26);
      do_ack(1, "R5 non b", got);
      do_eoi(0, 26);
      do_eoi(1, 26);
      // R12: set-pending in the same cycle as the acknowledge
      irq_prio[27*8 +: 8] = 8'h10;
      pulse(1, 27);
      settle_check("R12 setup");
      while (!cmd_ready) @(negedge clk);
      e = model_ack(1);
      m_pend[1][27] = 1;
      cmd_valid = 1; cmd_cpu = 1'b1; cmd_op = 2'd0; cmd_data = '0;
      pend_set[27*NC + 1] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 0; pend_set = '0;
      chk("R12 ack id", int'(rsp_id), e);
      settle_check("R12 kept");
      chk("R12 still pending", hp(1), 27);
      // R4: same priority as running is not granted
      do_ack(1, "R4 equal prio", got);
      chk("R4 refused", got, NONE);
      do_eoi(1, 27);
      do_ack(1, "R12 drain", got);
      do_eoi(1, 27);
      // R3: processor interface off
      cpu_en[1] = 0;
      pulse(1, 28);
      settle_check("R3 cpu off");
      chk("R3 cpu off hp1", hp(1), NONE);
      do_ack(1, "R4 gated", got);
      chk("R4 gated none", got, NONE);
      cpu_en[1] = 1;
      // random phase: priorities fixed from here on
      for (int k = 0; k < NI; k++) irq_prio[k*8 +: 8] = 8'(($urandom % 8) * 24 + 8);
      for (int n = 0; n < 300; n++) begin
         c = int'($urandom % NC);
         i = int'($urandom % NI);
         r = int'($urandom % 8);
         case (r)
            0, 1: pulse(c, i);
            2, 3: do_ack(c, "R5 random", got);
            4: if (m_run[c] != NONE) do_eoi(c, m_run[c]); else do_eoi(c, i);
            5: begin
               if (m_run[c] != NONE && m_chain[c][m_run[c]] != NONE && ($urandom % 2) == 1)
                  do_eoi(c, m_chain[c][m_run[c]]);
               else if (($urandom % 8) == 0) do_eoi(c, NONE);
               else do_eoi(c, i);
            end
            6: do_mask(c, ($urandom % 4 == 0) ? int'($urandom % 1024) : 255, lc);
            default: begin
               case ($urandom % 5)
                  0: irq_en[i] = ~irq_en[i];
                  1: irq_level[i] = ~irq_level[i];
                  2: irq_edge[i] = ~irq_edge[i];
                  3: irq_target[i*NC + c] = ~irq_target[i*NC + c];
                  default: if (($urandom % 4) == 0) dist_en = ~dist_en; else dist_en = 1;
               endcase
            end
         endcase
         settle_check("R2 random");
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule